// File: doc/BRIEF.md
# Scalar Memory Read Issue Unit

This unit sits between the scalar instruction stream and the constant-data memory port. It receives 32-bit scalar memory-read instruction words and decodes each one. It then issues a single request on a valid/ready memory port. The request carries the operation kind, the effective byte address, the number of dwords to fetch and the destination register index. A load may take its offset in one of three ways: from the instruction itself, from a scalar register, or from a literal dword that follows the instruction on the same input. The unit reads the register file through two combinational read ports. One returns the base address of the selected register pair. The other returns the contents of an offset register.

Every issued operation adds a weight to an outstanding-operation counter. The weight is 1 for a fetch of at most one dword and 2 for a fetch of more than one. Each completion subtracts the weight it reports. Completions may arrive in any order, so consumers hold off until the wait flag shows that the counter is empty. Malformed words produce a one-cycle illegal pulse and no request.

Top module: `smem_issue`

## Requirements
- R1: An instruction word whose bits 31:27 are not 5'b11000 raises `illegal` for one cycle, after the cycle that accepted it. It issues no request and leaves `pending_cnt` unchanged.
- R2: Opcode field bits 26:22 values 5–7 and 13–28 are undefined. They behave as in R1.
- R3: With bit 8 (offset mode) set to 1, the load address is base + 4 × bits 7:0.
- R4: With bit 8 cleared and bits 7:0 not 8'hFF, `off_sel` shows bits 7:0. The address is base + (`off_val` with its two low bits cleared).
- R5: With bit 8 cleared and bits 7:0 equal to 8'hFF on a load, no request is raised until the next word has been accepted. That next word is a byte offset, and the address is base + (literal with its two low bits cleared).
- R6: Opcodes 0–4 are plain loads (`req_kind` 0) of 1, 2, 4, 8 and 16 dwords. Opcodes 8–12 are descriptor-based loads (`req_kind` 1) of the same sizes. In both cases `req_dst` is bits 21:15 and `base_sel` is bits 14:9.
- R7: A descriptor-based load whose bits 14:9 are odd is handled as in R1.
- R8: Opcode 30 is a clock read (`req_kind` 2, 2 dwords). Opcode 31 invalidates the whole cache (`req_kind` 3). Opcode 29 invalidates volatile lines only (`req_kind` 4). The two invalidates carry 0 dwords. All three carry address 0.
- R9: An accepted request raises `pending_cnt` in the next cycle. It adds 2 when `req_dwords` is above 1 and adds 1 otherwise.
- R10: A completion lowers the counter by 2 when `cpl_multi` is 1 and by 1 otherwise. A request and a completion in the same cycle are netted together.
- R11: The counter saturates at 2^CNT_W−1 and does not go below 0.
- R12: While `req_ready` is low, `req_valid` stays high and the request fields stay stable. During that time `instr_ready` is low and input words are ignored.
- R13: `wait_zero` is high exactly when the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction or literal word present |
| instr_word | input | 32 | Instruction or literal word |
| instr_ready | output | 1 | Unit can take a word |
| base_sel | output | 6 | Register pair index for base lookup |
| base_val | input | ADDR_W | Base address of the selected pair |
| off_sel | output | 8 | Register index holding a byte offset |
| off_val | input | 32 | Contents of that register |
| req_valid | output | 1 | Memory request present |
| req_ready | input | 1 | Memory port accepts the request |
| req_kind | output | 3 | 0 load, 1 descriptor load, 2 clock read, 3 full invalidate, 4 volatile invalidate |
| req_addr | output | ADDR_W | Effective byte address |
| req_dwords | output | 5 | Dwords to fetch |
| req_dst | output | 7 | Destination register index |
| cpl_valid | input | 1 | One operation completed |
| cpl_multi | input | 1 | Completed operation had weight 2 |
| pending_cnt | output | CNT_W | Weighted outstanding count |
| wait_zero | output | 1 | Counter is empty |
| illegal | output | 1 | Malformed word pulse |

## Verification
The first sweep drives all 32 opcode values with an immediate offset. This separates the legal opcodes from the undefined ones and checks kind, size, weight and address for each size. A sweep over the encoding field shows that only the single valid tag is accepted. Separate runs cover the register-offset and literal modes, each with offsets that have their two low bits set, so that a missing alignment mask shows up as a wrong address. Counter patterns then cover back-to-back issue into saturation, draining below zero, a request and a completion in the same cycle, and a stalled port with a word offered during the stall.

// File: rtl/smem_pkg.sv
// Shared types for the scalar memory read issue unit.
// Assumes 32-bit instruction words with a fixed field layout.
package smem_pkg;
    localparam logic [4:0] ENC_TAG = 5'b11000;
    localparam logic [4:0] OP_INV_VOL = 5'd29;
    localparam logic [4:0] OP_CLOCK   = 5'd30;
    localparam logic [4:0] OP_INV_ALL = 5'd31;

    typedef enum logic [2:0] {
        KIND_LOAD    = 3'd0,
        KIND_BUF     = 3'd1,
        KIND_CLOCK   = 3'd2,
        KIND_INV_ALL = 3'd3,
        KIND_INV_VOL = 3'd4
    } smem_kind_e;

    typedef struct packed {
        logic       legal;
        logic       needs_lit;
        smem_kind_e kind;
        logic [4:0] dwords;
        logic       imm;
        logic [7:0] offset;
        logic [5:0] sbase;
        logic [6:0] sdst;
    } smem_dec_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LIT   = 2'd1,
        ST_ISSUE = 2'd2
    } smem_state_e;
endpackage

// File: rtl/smem_decode.sv
// Combinational decoder: splits an instruction word into fields,
// classifies the opcode and flags malformed words.
// Assumes the word is only meaningful when the caller samples it.
module smem_decode
    import smem_pkg::*;
(
    input  logic [31:0] word,
    output smem_dec_t   dec
);
    logic [4:0] op;
    logic       op_ok;

    assign op = word[26:22];

    // Classify opcode, size and legality.
    always_comb begin
        dec        = '0;
        op_ok      = 1'b1;
        dec.imm    = word[8];
        dec.offset = word[7:0];
        dec.sbase  = word[14:9];
        dec.sdst   = word[21:15];
        dec.kind   = KIND_LOAD;
        dec.dwords = 5'd0;
        if (op <= 5'd4) begin
            dec.kind   = KIND_LOAD;
            dec.dwords = 5'd1 << op[2:0];
        end else if (op >= 5'd8 && op <= 5'd12) begin
            dec.kind   = KIND_BUF;
            dec.dwords = 5'd1 << op[2:0];
            op_ok      = ~word[9];
        end else begin
            case (op)
                OP_INV_VOL: dec.kind = KIND_INV_VOL;
                OP_CLOCK: begin
                    dec.kind   = KIND_CLOCK;
                    dec.dwords = 5'd2;
                end
                OP_INV_ALL: dec.kind = KIND_INV_ALL;
                default:    op_ok = 1'b0;
            endcase
        end
        dec.legal     = (word[31:27] == ENC_TAG) && op_ok;
        dec.needs_lit = dec.legal && !word[8] && (word[7:0] == 8'hFF)
                        && (dec.kind == KIND_LOAD || dec.kind == KIND_BUF);
    end
endmodule

// File: rtl/smem_addr.sv
// Effective address generator: base plus a dword-aligned byte offset.
// The offset comes from the immediate field, a register or a literal.
module smem_addr #(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] base,
    input  logic              imm,
    input  logic [7:0]        offset,
    input  logic              use_lit,
    input  logic [31:0]       lit,
    input  logic [31:0]       reg_off,
    output logic [ADDR_W-1:0] addr
);
    logic [31:0] byte_off;

    // Pick the offset source and clear its low two bits.
    always_comb begin
        if (imm)
            byte_off = {22'd0, offset, 2'b00};
        else if (use_lit)
            byte_off = lit & ~32'h3;
        else
            byte_off = reg_off & ~32'h3;
    end

    assign addr = base + ADDR_W'(byte_off);
endmodule

// File: rtl/smem_credit.sv
// Weighted outstanding-operation counter. It adds 1 or 2 at issue and
// subtracts 1 or 2 at completion, nets both in one cycle, and clamps
// to the range 0..2^CNT_W-1.
module smem_credit #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_en,
    input  logic             inc_two,
    input  logic             dec_en,
    input  logic             dec_two,
    output logic [CNT_W-1:0] cnt
);
    localparam int SUM_W = CNT_W + 2;
    localparam logic [SUM_W-1:0] MAXV = SUM_W'((1 << CNT_W) - 1);

    logic [SUM_W-1:0] inc_amt, dec_amt, sum, nxt;

    // Form the netted and clamped next count.
    always_comb begin
        inc_amt = inc_en ? (inc_two ? SUM_W'(2) : SUM_W'(1)) : '0;
        dec_amt = dec_en ? (dec_two ? SUM_W'(2) : SUM_W'(1)) : '0;
        sum     = {2'b00, cnt} + inc_amt;
        if (sum < dec_amt)
            nxt = '0;
        else
            nxt = sum - dec_amt;
        if (nxt > MAXV)
            nxt = MAXV;
    end

    // Hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else
            cnt <= nxt[CNT_W-1:0];
    end
endmodule

// File: rtl/smem_issue.sv
// Scalar memory read issue unit (top). It accepts one instruction word,
// plus an optional literal word, then holds a single request until the
// memory port takes it. It tracks outstanding work with a weighted counter.
// Assumes register read ports answer in the same cycle.
module smem_issue
    import smem_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [31:0]       instr_word,
    output logic              instr_ready,
    output logic [5:0]        base_sel,
    input  logic [ADDR_W-1:0] base_val,
    output logic [7:0]        off_sel,
    input  logic [31:0]       off_val,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [2:0]        req_kind,
    output logic [ADDR_W-1:0] req_addr,
    output logic [4:0]        req_dwords,
    output logic [6:0]        req_dst,
    input  logic              cpl_valid,
    input  logic              cpl_multi,
    output logic [CNT_W-1:0]  pending_cnt,
    output logic              wait_zero,
    output logic              illegal
);
    smem_state_e       state_q;
    smem_dec_t         dec, held_q;
    logic [31:0]       lit_q;
    logic              illegal_q;
    logic [ADDR_W-1:0] eff_addr;
    logic              fire;
    logic              is_load;

    smem_decode u_dec (
        .word (instr_word),
        .dec  (dec)
    );

    smem_addr #(.ADDR_W(ADDR_W)) u_addr (
        .base    (base_val),
        .imm     (held_q.imm),
        .offset  (held_q.offset),
        .use_lit (held_q.needs_lit),
        .lit     (lit_q),
        .reg_off (off_val),
        .addr    (eff_addr)
    );

    smem_credit #(.CNT_W(CNT_W)) u_credit (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_en  (fire),
        .inc_two (held_q.dwords > 5'd1),
        .dec_en  (cpl_valid),
        .dec_two (cpl_multi),
        .cnt     (pending_cnt)
    );

    // Sequence word capture, literal capture and request hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            held_q    <= '0;
            lit_q     <= '0;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (instr_valid) begin
                    if (!dec.legal) begin
                        illegal_q <= 1'b1;
                    end else begin
                        held_q  <= dec;
                        state_q <= dec.needs_lit ? ST_LIT : ST_ISSUE;
                    end
                end
                ST_LIT: if (instr_valid) begin
                    lit_q   <= instr_word;
                    state_q <= ST_ISSUE;
                end
                ST_ISSUE: if (req_ready) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign is_load     = (held_q.kind == KIND_LOAD) || (held_q.kind == KIND_BUF);
    assign instr_ready = (state_q != ST_ISSUE);
    assign req_valid   = (state_q == ST_ISSUE);
    assign fire        = req_valid && req_ready;
    assign base_sel    = held_q.sbase;
    assign off_sel     = held_q.offset;
    assign req_kind    = held_q.kind;
    assign req_addr    = is_load ? eff_addr : '0;
    assign req_dwords  = held_q.dwords;
    assign req_dst     = held_q.sdst;
    assign wait_zero   = (pending_cnt == '0);
    assign illegal     = illegal_q;
endmodule

// File: rtl/smem_issue_chk.sv
// Property checker for smem_issue. It watches the top-level ports only
// and is attached through the bind at the end of this file.
module smem_issue_chk #(
    parameter int ADDR_W = 64,
    parameter int CNT_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_ready,
    input logic              req_valid,
    input logic              req_ready,
    input logic [2:0]        req_kind,
    input logic [ADDR_W-1:0] req_addr,
    input logic [4:0]        req_dwords,
    input logic [6:0]        req_dst,
    input logic              cpl_valid,
    input logic              cpl_multi,
    input logic [CNT_W-1:0]  pending_cnt,
    input logic              wait_zero,
    input logic              illegal
);
    localparam int MAXV = (1 << CNT_W) - 1;

    // R12: a stalled request keeps its fields
    a_r12_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
            && $stable(req_kind) && $stable(req_dwords) && $stable(req_dst)));

    // R12: no word is taken while a request is pending
    a_r12_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !instr_ready);

    // R1: an illegal pulse never coincides with a request
    a_r1_illegal_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !req_valid);

    // R8: invalidates carry no dwords
    a_r8_inv_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_kind == 3'd3 || req_kind == 3'd4)) |-> (req_dwords == 5'd0));

    // R9: the issue weight is added when there is headroom
    a_r9_inc_weight: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !cpl_valid && pending_cnt < CNT_W'(MAXV - 1))
        |=> (pending_cnt == $past(pending_cnt)
             + (($past(req_dwords) > 5'd1) ? CNT_W'(2) : CNT_W'(1))));

    // R10: the completion weight is removed when there is enough to remove
    a_r10_dec_weight: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !(req_valid && req_ready) && pending_cnt >= CNT_W'(2))
        |=> (pending_cnt == $past(pending_cnt)
             - ($past(cpl_multi) ? CNT_W'(2) : CNT_W'(1))));

    // R10: without issue or completion the count holds
    a_r10_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(req_valid && req_ready) && !cpl_valid) |=> $stable(pending_cnt));

    // R13: an empty counter stays empty without issue
    a_r13_empty_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_zero && !(req_valid && req_ready)) |=> wait_zero);
endmodule

bind smem_issue smem_issue_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_ready (instr_ready),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_kind    (req_kind),
    .req_addr    (req_addr),
    .req_dwords  (req_dwords),
    .req_dst     (req_dst),
    .cpl_valid   (cpl_valid),
    .cpl_multi   (cpl_multi),
    .pending_cnt (pending_cnt),
    .wait_zero   (wait_zero),
    .illegal     (illegal)
);

// File: tb/tb_smem_issue.sv
module tb_smem_issue;
    localparam int ADDR_W = 64;
    localparam int CNT_W  = 6;
    localparam int MAXV   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              instr_valid = 1'b0;
    logic [31:0]       instr_word = '0;
    logic              instr_ready;
    logic [5:0]        base_sel;
    logic [ADDR_W-1:0] base_val;
    logic [7:0]        off_sel;
    logic [31:0]       off_val;
    logic              req_valid;
    logic              req_ready = 1'b1;
    logic [2:0]        req_kind;
    logic [ADDR_W-1:0] req_addr;
    logic [4:0]        req_dwords;
    logic [6:0]        req_dst;
    logic              cpl_valid = 1'b0;
    logic              cpl_multi = 1'b0;
    logic [CNT_W-1:0]  pending_cnt;
    logic              wait_zero;
    logic              illegal;

    int nvec = 0;
    int nfail = 0;
    int cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    function automatic logic [63:0] base_of(input logic [5:0] s);
        return 64'h4000_0000_0000_0000 + (64'(s) << 20) + 64'(s) * 64'd3;
    endfunction
    function automatic logic [31:0] roff_of(input logic [7:0] s);
        return {s, 8'h5A, ~s, s};
    endfunction
    function automatic logic [31:0] mk(input logic [4:0] enc, input logic [4:0] op,
                                      input logic [6:0] dst, input logic [5:0] sb,
                                      input logic imm, input logic [7:0] off);
        return {enc, op, dst, sb, imm, off};
    endfunction

    assign base_val = base_of(base_sel);
    assign off_val  = roff_of(off_sel);

    smem_issue #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = w;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic complete(input logic two);
        cpl_valid = 1'b1;
        cpl_multi = two;
        @(negedge clk);
        cpl_valid = 1'b0;
        cpl_multi = 1'b0;
    endtask

    // Issue one word with the port ready, check fields, count and drain.
    task automatic run_one(input logic [31:0] w, input bit legal, input logic [2:0] kind,
                           input logic [4:0] dw, input logic [63:0] addr, input string tag);
        int wt;
        wt = (dw > 5'd1) ? 2 : 1;
        send(w);
        if (!legal) begin
            chk({tag, " illegal pulse"}, illegal, 1);
            chk({tag, " no request"}, req_valid, 0);
            @(negedge clk);
            chk({tag, " count unchanged"}, pending_cnt, 0);
            return;
        end
        chk({tag, " R6 valid"}, req_valid, 1);
        chk({tag, " R6 kind"}, req_kind, kind);
        chk({tag, " R6 dwords"}, req_dwords, dw);
        chk({tag, " R6 dst"}, req_dst, w[21:15]);
        chk({tag, " address"}, req_addr, addr);
        if (kind <= 3'd1) chk({tag, " R6 base_sel"}, base_sel, w[14:9]);
        @(negedge clk);
        chk({tag, " R9 weight"}, pending_cnt, wt);
        chk({tag, " R13 busy"}, wait_zero, 0);
        complete(wt == 2);
        chk({tag, " R10 drain"}, pending_cnt, 0);
        chk({tag, " R13 empty"}, wait_zero, 1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            nfail++;
            $display("FAIL watchdog: actual %0d expected below 50000 cycles", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset R12 valid", req_valid, 0);
        chk("reset R13 count", pending_cnt, 0);
        chk("reset R13 wait", wait_zero, 1);
        chk("reset R1 illegal", illegal, 0);
        chk("reset ready", instr_ready, 1);

        // Opcode sweep with immediate offsets: R2 R3 R6 R8.
        for (int op = 0; op < 32; op++) begin
            bit lg;
            logic [2:0] k;
            logic [4:0] dw;
            logic [5:0] sb;
            logic [7:0] off;
            logic [63:0] ea;
            sb  = 6'((op * 2) & 62);
            off = 8'(op * 7 + 1);
            lg  = (op <= 4) || (op >= 8 && op <= 12) || op >= 29;
            k = 3'd0; dw = 5'd0;
            if (op <= 4) begin k = 3'd0; dw = 5'(1 << op); end
            else if (op >= 8 && op <= 12) begin k = 3'd1; dw = 5'(1 << (op - 8)); end
            else if (op == 30) begin k = 3'd2; dw = 5'd2; end
            else if (op == 31) k = 3'd3;
            else if (op == 29) k = 3'd4;
            ea = (k <= 3'd1) ? base_of(sb) + 64'(off) * 64'd4 : 64'd0;
            run_one(mk(5'b11000, 5'(op), 7'(op + 3), sb, 1'b1, off), lg, k, dw, ea,
                    (lg ? ((op >= 29) ? "R8 op" : "R3 op") : "R2 op"));
        end

        // Encoding sweep: R1.
        for (int e = 0; e < 32; e++) begin
            if (e != 5'b11000)
                run_one(mk(5'(e), 5'd1, 7'd9, 6'd2, 1'b1, 8'd4), 0, 3'd0, 5'd0, 64'd0, "R1 enc");
        end

        // Odd base on descriptor loads: R7.
        run_one(mk(5'b11000, 5'd9, 7'd5, 6'd3, 1'b1, 8'd2), 0, 3'd1, 5'd0, 64'd0, "R7 odd");
        run_one(mk(5'b11000, 5'd2, 7'd5, 6'd3, 1'b1, 8'd2), 1, 3'd0, 5'd4,
                base_of(6'd3) + 64'd8, "R7 plain odd ok");

        // Register offset mode: R4.
        for (int i = 0; i < 8; i++) begin
            logic [7:0] rs;
            rs = 8'(i * 37 + 1);
            run_one(mk(5'b11000, 5'(i % 5), 7'd20, 6'(i * 2), 1'b0, rs), 1, 3'd0,
                    5'(1 << (i % 5)),
                    base_of(6'(i * 2)) + 64'(roff_of(rs) & ~32'h3), "R4 regoff");
        end

        // Literal mode: R5.
        send(mk(5'b11000, 5'd10, 7'd40, 6'd4, 1'b0, 8'hFF));
        chk("R5 no request before literal", req_valid, 0);
        chk("R5 ready for literal", instr_ready, 1);
        send(32'h0000_1237);
        chk("R5 request after literal", req_valid, 1);
        chk("R5 literal address", req_addr, base_of(6'd4) + 64'h1234);
        chk("R5 dwords", req_dwords, 4);
        @(negedge clk);
        complete(1'b1);
        chk("R5 drained", pending_cnt, 0);

        // Stall: R12.
        req_ready = 1'b0;
        send(mk(5'b11000, 5'd2, 7'd11, 6'd6, 1'b1, 8'd3));
        instr_valid = 1'b1;
        instr_word  = mk(5'b11000, 5'd0, 7'd12, 6'd8, 1'b1, 8'd1);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R12 held valid", req_valid, 1);
            chk("R12 held addr", req_addr, base_of(6'd6) + 64'd12);
            chk("R12 held dst", req_dst, 11);
            chk("R12 not ready", instr_ready, 0);
            chk("R12 count idle", pending_cnt, 0);
        end
        instr_valid = 1'b0;
        req_ready = 1'b1;
        @(negedge clk);
        chk("R12 fired once", pending_cnt, 2);
        chk("R12 no second request", req_valid, 0);
        complete(1'b1);

        // Saturation: R11.
        for (int n = 0; n < 32; n++) begin
            send(mk(5'b11000, 5'd1, 7'd1, 6'd0, 1'b1, 8'd0));
            @(negedge clk);
        end
        chk("R11 saturate", pending_cnt, MAXV);
        send(mk(5'b11000, 5'd0, 7'd1, 6'd0, 1'b1, 8'd0));
        @(negedge clk);
        chk("R11 stays at max", pending_cnt, MAXV);
        complete(1'b1);
        chk("R10 multi dec", pending_cnt, MAXV - 2);

        // Netting: R10 (single issue with multi completion).
        send(mk(5'b11000, 5'd0, 7'd1, 6'd0, 1'b1, 8'd0));
        complete(1'b1);
        chk("R10 netted", pending_cnt, MAXV - 3);
        complete(1'b0);
        chk("R10 single dec", pending_cnt, MAXV - 4);

        // Drain below zero: R11 R13.
        for (int n = 0; n < 40; n++) complete(1'b1);
        chk("R11 floor", pending_cnt, 0);
        chk("R13 drained", wait_zero, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule